// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block answers a load's question "which of my bytes are already being written by an older store still sitting in the store queue, and with what value?". The store queue's contents are presented to it as flat vectors by the queue's owner. Each entry carries the following:

- an occupancy bit;
- an address-known bit and a data-known bit;
- a virtual and a physical address;
- an 8-bit byte-lane mask;
- 64 bits of data.

Age follows entry index: a higher index is younger. A load request carries its virtual and physical address, its byte-lane mask, and a precomputed vector with one bit per queue entry that marks the entries older than the load.

The answer comes in two steps. In the request cycle, the block gives a fast byte mask and a fast data-pending flag, both combinational. One clock later, registered results appear:

- the full byte mask and the eight forwarded bytes;
- a data-pending flag with the index of the store whose data is missing;
- an address-pending flag with the index of the store whose address is unknown;
- an alias flag.

The alias flag is raised when the virtual and the physical compares disagree. Forwarding itself follows the virtual compare. The physical compare is used only to detect aliasing, which the surrounding pipeline turns into a flush.

Top module: `fwd_lookup`

## Requirements
- R1: While reset is asserted, and at the first clock after its release, res_valid, res_mask, res_data, both pending flags, both indices and res_alias are all zero.
- R2: res_valid is high exactly one clock after a cycle with ld_valid high. Whenever res_valid is low, res_mask, res_data, res_data_pend, res_addr_pend and res_alias are zero.
- R3: A queue entry is a contributor for byte lane L only when all of the following hold:
  - its sq_valid bit and its ld_older bit are both 1, and sq_addr_ok is 1;
  - its virtual address matches the load's above bit 3 (8-byte aligned);
  - bit L is set in both the store mask and the load mask.
  Entries that are younger or empty never affect any output.
- R4: For each lane with at least one contributor, res_mask bit L is 1. res_data bits [8L+7:8L] then equal bits [64i+8L+7:64i+8L] of sq_data, where i is the highest-index contributor for that lane (the youngest older store wins).
- R5: A lane with no contributor has res_mask bit L at 0 and res_data byte L at 0.
- R6: In the request cycle, fast_mask equals the lane mask that res_mask shows one clock later. fast_mask and fast_data_pend are zero when ld_valid is low.
- R7: If any entry that contributes to at least one lane has sq_data_ok at 0, then fast_data_pend is 1 in the request cycle and res_data_pend is 1 one clock later. res_data_pend_idx is the highest such entry index, and 0 when there is none.
- R8: If any occupied older entry has sq_addr_ok at 0, res_addr_pend is 1 one clock later. res_addr_pend_idx is the highest such entry index, and 0 when there is none.
- R9: res_alias is 1 one clock after a request if, for some occupied older entry with a known address, the lanes hit under the virtual compare differ from the lanes hit under the physical compare. The physical compare uses physical address bits above bit 3 and the same lane overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sq_valid | input | N | Entry occupied |
| sq_addr_ok | input | N | Entry address known |
| sq_data_ok | input | N | Entry data known |
| sq_vaddr | input | N*VA | Entry virtual addresses, entry i at [VA*i +: VA] |
| sq_paddr | input | N*PA | Entry physical addresses, entry i at [PA*i +: PA] |
| sq_mask | input | N*8 | Entry byte masks, entry i at [8*i +: 8] |
| sq_data | input | N*64 | Entry data, entry i at [64*i +: 64] |
| ld_valid | input | 1 | Load request present |
| ld_vaddr | input | VA | Load virtual address |
| ld_paddr | input | PA | Load physical address |
| ld_mask | input | 8 | Load byte mask |
| ld_older | input | N | One bit per entry: entry is older than the load |
| fast_mask | output | 8 | Request-cycle forward lane mask |
| fast_data_pend | output | 1 | Request-cycle data-pending flag |
| res_valid | output | 1 | Stage-2 results valid |
| res_mask | output | 8 | Stage-2 forward lane mask |
| res_data | output | 64 | Stage-2 forwarded bytes |
| res_data_pend | output | 1 | Matching older store lacks data |
| res_data_pend_idx | output | $clog2(N) | Index of that store |
| res_addr_pend | output | 1 | Older store lacks address |
| res_addr_pend_idx | output | $clog2(N) | Index of that store |
| res_alias | output | 1 | Virtual/physical match disagreement |

## Verification
The fast outputs are due in the request cycle itself, with no register in between. The bench therefore drives a request just after a falling edge and samples fast_mask and fast_data_pend one time unit later, before the next rising edge. Every stage-2 output passes through exactly one register. The bench samples those outputs one time unit after the following rising edge, while the request inputs are still held, and compares them with a reference model evaluated on the same held queue image.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int LANES = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int OFS_W = $clog2(LANES);
  typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/fwd_hi_pick.sv
module fwd_hi_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/fwd_entry_cmp.sv
module fwd_entry_cmp
  import fwd_pkg::*;
#(
  parameter int VA = 39,
  parameter int PA = 36
) (
  input  logic      live,
  input  logic      addr_ok,
  input  logic      data_ok,
  input  logic [VA-1:0] st_vaddr,
  input  logic [PA-1:0] st_paddr,
  input  lane_vec_t st_mask,
  input  logic [VA-1:0] ld_vaddr,
  input  logic [PA-1:0] ld_paddr,
  input  lane_vec_t ld_mask,
  output lane_vec_t vhit,
  output lane_vec_t phit,
  output logic      data_pend,
  output logic      addr_pend
);
  logic      known;
  logic      veq;
  logic      peq;
  lane_vec_t overlap;

  always_comb begin
    known     = live & addr_ok;
    veq       = (st_vaddr[VA-1:OFS_W] == ld_vaddr[VA-1:OFS_W]);
    peq       = (st_paddr[PA-1:OFS_W] == ld_paddr[PA-1:OFS_W]);
    overlap   = st_mask & ld_mask;
    vhit      = (known && veq) ? overlap : '0;
    phit      = (known && peq) ? overlap : '0;
    addr_pend = live & ~addr_ok;
    data_pend = (|vhit) & ~data_ok;
  end
endmodule

// File: rtl/fwd_lookup.sv
module fwd_lookup
  import fwd_pkg::*;
#(
  parameter int N  = 8,
  parameter int VA = 39,
  parameter int PA = 36,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      sq_valid,
  input  logic [N-1:0]      sq_addr_ok,
  input  logic [N-1:0]      sq_data_ok,
  input  logic [N*VA-1:0]   sq_vaddr,
  input  logic [N*PA-1:0]   sq_paddr,
  input  logic [N*8-1:0]    sq_mask,
  input  logic [N*64-1:0]   sq_data,
  input  logic              ld_valid,
  input  logic [VA-1:0]     ld_vaddr,
  input  logic [PA-1:0]     ld_paddr,
  input  logic [7:0]        ld_mask,
  input  logic [N-1:0]      ld_older,
  output logic [7:0]        fast_mask,
  output logic              fast_data_pend,
  output logic              res_valid,
  output logic [7:0]        res_mask,
  output logic [63:0]       res_data,
  output logic              res_data_pend,
  output logic [IW-1:0]     res_data_pend_idx,
  output logic              res_addr_pend,
  output logic [IW-1:0]     res_addr_pend_idx,
  output logic              res_alias
);
  logic [N-1:0]                 live;
  lane_vec_t [N-1:0]            vhit_e;
  lane_vec_t [N-1:0]            phit_e;
  logic [N-1:0]                 dpend_e;
  logic [N-1:0]                 apend_e;
  logic [N-1:0]                 alias_e;
  logic [LANES-1:0][N-1:0]      lane_req;
  lane_vec_t                    lane_found;
  logic [LANES-1:0][IW-1:0]     lane_idx;
  logic [WORD_W-1:0]            comb_data;
  logic                         dp_any;
  logic                         ap_any;
  logic [IW-1:0]                dp_idx;
  logic [IW-1:0]                ap_idx;

  assign live = sq_valid & ld_older & {N{ld_valid}};

  for (genvar e = 0; e < N; e++) begin : g_ent
    fwd_entry_cmp #(.VA(VA), .PA(PA)) u_cmp (
      .live      (live[e]),
      .addr_ok   (sq_addr_ok[e]),
      .data_ok   (sq_data_ok[e]),
      .st_vaddr  (sq_vaddr[VA*e +: VA]),
      .st_paddr  (sq_paddr[PA*e +: PA]),
      .st_mask   (sq_mask[8*e +: 8]),
      .ld_vaddr  (ld_vaddr),
      .ld_paddr  (ld_paddr),
      .ld_mask   (ld_mask),
      .vhit      (vhit_e[e]),
      .phit      (phit_e[e]),
      .data_pend (dpend_e[e]),
      .addr_pend (apend_e[e])
    );
    assign alias_e[e] = (vhit_e[e] != phit_e[e]);
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      for (int e = 0; e < N; e++) lane_req[l][e] = vhit_e[e][l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fwd_hi_pick #(.N(N)) u_pick (
      .req   (lane_req[l]),
      .found (lane_found[l]),
      .idx   (lane_idx[l])
    );
    assign comb_data[BYTE_W*l +: BYTE_W] = lane_found[l]
      ? sq_data[WORD_W*int'(lane_idx[l]) + BYTE_W*l +: BYTE_W] : '0;
  end

  fwd_hi_pick #(.N(N)) u_dpick (.req(dpend_e), .found(dp_any), .idx(dp_idx));
  fwd_hi_pick #(.N(N)) u_apick (.req(apend_e), .found(ap_any), .idx(ap_idx));

  assign fast_mask      = lane_found;
  assign fast_data_pend = dp_any;

  // next-state for the stage-2 register set
  logic              nx_valid;
  logic [7:0]        nx_mask;
  logic [63:0]       nx_data;
  logic              nx_dp;
  logic [IW-1:0]     nx_dpi;
  logic              nx_ap;
  logic [IW-1:0]     nx_api;
  logic              nx_alias;

  always_comb begin
    nx_valid = ld_valid;
    nx_mask  = '0;
    nx_data  = '0;
    nx_dp    = 1'b0;
    nx_dpi   = '0;
    nx_ap    = 1'b0;
    nx_api   = '0;
    nx_alias = 1'b0;
    if (ld_valid) begin
      nx_mask  = lane_found;
      nx_data  = comb_data;
      nx_dp    = dp_any;
      nx_dpi   = dp_idx;
      nx_ap    = ap_any;
      nx_api   = ap_idx;
      nx_alias = |alias_e;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid         <= 1'b0;
      res_mask          <= '0;
      res_data          <= '0;
      res_data_pend     <= 1'b0;
      res_data_pend_idx <= '0;
      res_addr_pend     <= 1'b0;
      res_addr_pend_idx <= '0;
      res_alias         <= 1'b0;
    end else begin
      res_valid         <= nx_valid;
      res_mask          <= nx_mask;
      res_data          <= nx_data;
      res_data_pend     <= nx_dp;
      res_data_pend_idx <= nx_dpi;
      res_addr_pend     <= nx_ap;
      res_addr_pend_idx <= nx_api;
      res_alias         <= nx_alias;
    end
  end
endmodule

// File: rtl/fwd_lookup_chk.sv
module fwd_lookup_chk #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic [7:0]    ld_mask,
  input logic [N-1:0]  ld_older,
  input logic [7:0]    fast_mask,
  input logic          fast_data_pend,
  input logic          res_valid,
  input logic [7:0]    res_mask,
  input logic [63:0]   res_data,
  input logic          res_data_pend,
  input logic [IW-1:0] res_data_pend_idx,
  input logic          res_addr_pend,
  input logic [IW-1:0] res_addr_pend_idx,
  input logic          res_alias
);
  logic [N-1:0] older_q;
  always_ff @(posedge clk) older_q <= ld_older;

  assert_stage_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);
  assert_stage_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_mask == 8'h00 && res_data == 64'h0 && !res_data_pend
                    && !res_addr_pend && !res_alias));
  assert_mask_within_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ((res_mask & ~$past(ld_mask)) == 8'h00));
  assert_fast_ahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (res_mask == $past(fast_mask)));
  assert_fast_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (fast_mask == 8'h00 && !fast_data_pend));
  assert_pend_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (res_data_pend == $past(fast_data_pend)));
  assert_data_idx_older_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_data_pend |-> older_q[res_data_pend_idx]);
  assert_addr_idx_older_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_addr_pend |-> older_q[res_addr_pend_idx]);
endmodule

bind fwd_lookup fwd_lookup_chk #(.N(N)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .ld_valid          (ld_valid),
  .ld_mask           (ld_mask),
  .ld_older          (ld_older),
  .fast_mask         (fast_mask),
  .fast_data_pend    (fast_data_pend),
  .res_valid         (res_valid),
  .res_mask          (res_mask),
  .res_data          (res_data),
  .res_data_pend     (res_data_pend),
  .res_data_pend_idx (res_data_pend_idx),
  .res_addr_pend     (res_addr_pend),
  .res_addr_pend_idx (res_addr_pend_idx),
  .res_alias         (res_alias)
);

// File: tb/sim_fwd_lookup.sv
module sim_fwd_lookup;
  localparam int N = 8;
  localparam int VA = 39;
  localparam int PA = 36;
  localparam int IW = 3;
  localparam int PERIOD = 10;
  localparam logic [VA-4:0] VBASE = 'h1a2b0;
  localparam logic [PA-4:0] PBASE = 'h05c40;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] sq_valid, sq_addr_ok, sq_data_ok, ld_older;
  logic [N*VA-1:0] sq_vaddr;
  logic [N*PA-1:0] sq_paddr;
  logic [N*8-1:0] sq_mask;
  logic [N*64-1:0] sq_data;
  logic ld_valid;
  logic [VA-1:0] ld_vaddr;
  logic [PA-1:0] ld_paddr;
  logic [7:0] ld_mask;
  logic [7:0] fast_mask, res_mask;
  logic fast_data_pend, res_valid, res_data_pend, res_addr_pend, res_alias;
  logic [63:0] res_data;
  logic [IW-1:0] res_data_pend_idx, res_addr_pend_idx;

  int checks = 0;
  int errors = 0;
  logic [7:0] x_mask;
  logic [63:0] x_data;
  logic x_dp, x_ap, x_alias;
  logic [IW-1:0] x_dpi, x_api;

  always #(PERIOD/2) clk = ~clk;

  fwd_lookup #(.N(N), .VA(VA), .PA(PA)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference: scan youngest first, first hit wins
  task automatic model();
    x_mask = '0; x_data = '0; x_dp = 0; x_ap = 0; x_alias = 0; x_dpi = '0; x_api = '0;
    for (int e = N - 1; e >= 0; e--) begin
      logic use_e, vm, pm;
      logic [7:0] ov, vh, ph;
      use_e = ld_valid && sq_valid[e] && ld_older[e];
      if (!use_e) continue;
      if (!sq_addr_ok[e]) begin
        if (!x_ap) begin x_ap = 1; x_api = IW'(e); end
        continue;
      end
      vm = sq_vaddr[VA*e+3 +: VA-3] == ld_vaddr[VA-1:3];
      pm = sq_paddr[PA*e+3 +: PA-3] == ld_paddr[PA-1:3];
      ov = sq_mask[8*e +: 8] & ld_mask;
      vh = vm ? ov : 8'h0;
      ph = pm ? ov : 8'h0;
      if (vh != ph) x_alias = 1;
      if (vh != 0 && !sq_data_ok[e] && !x_dp) begin x_dp = 1; x_dpi = IW'(e); end
      for (int l = 0; l < 8; l++) begin
        if (vh[l] && !x_mask[l]) begin
          x_mask[l] = 1;
          x_data[8*l +: 8] = sq_data[64*e + 8*l +: 8];
        end
      end
    end
  endtask

  task automatic set_entry(input int e, input logic v, input logic a, input logic d,
                           input int vline, input int pline, input logic [7:0] m,
                           input logic [63:0] dat);
    sq_valid[e] = v; sq_addr_ok[e] = a; sq_data_ok[e] = d;
    sq_vaddr[VA*e +: VA] = {VBASE + (VA-3)'(vline), 3'($urandom)};
    sq_paddr[PA*e +: PA] = {PBASE + (PA-3)'(pline), 3'($urandom)};
    sq_mask[8*e +: 8] = m;
    sq_data[64*e +: 64] = dat;
  endtask

  task automatic set_load(input int line, input logic [7:0] m, input logic [N-1:0] old);
    ld_valid = 1;
    ld_vaddr = {VBASE + (VA-3)'(line), 3'($urandom)};
    ld_paddr = {PBASE + (PA-3)'(line), 3'($urandom)};
    ld_mask = m; ld_older = old;
  endtask

  // inputs set after a falling edge; fast outputs checked before the rising
  // edge, registered outputs one unit after it
  task automatic run(input string tag);
    model();
    #1;
    chk({tag, " R6 fast_mask"}, 64'(fast_mask), 64'(x_mask));
    chk({tag, " R7 fast_data_pend"}, 64'(fast_data_pend), 64'(x_dp));
    @(posedge clk); #1;
    chk({tag, " R2 res_valid"}, 64'(res_valid), 64'(ld_valid));
    chk({tag, " R4 res_mask"}, 64'(res_mask), 64'(x_mask));
    chk({tag, " R4 R5 res_data"}, res_data, x_data);
    chk({tag, " R7 res_data_pend"}, 64'(res_data_pend), 64'(x_dp));
    chk({tag, " R7 data idx"}, 64'(res_data_pend_idx), 64'(x_dpi));
    chk({tag, " R8 res_addr_pend"}, 64'(res_addr_pend), 64'(x_ap));
    chk({tag, " R8 addr idx"}, 64'(res_addr_pend_idx), 64'(x_api));
    chk({tag, " R9 res_alias"}, 64'(res_alias), 64'(x_alias));
    @(negedge clk);
  endtask

  task automatic clear_q();
    for (int e = 0; e < N; e++) set_entry(e, 0, 1, 1, 5, 5, 8'h00, 64'h0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; ld_valid = 0; ld_vaddr = '0; ld_paddr = '0; ld_mask = '0; ld_older = '0;
    clear_q();
    repeat (3) @(negedge clk);
    chk("R1 reset res_valid", 64'(res_valid), 64'h0);
    chk("R1 reset res_mask/data", 64'(res_mask) | res_data, 64'h0);
    chk("R1 reset flags", 64'({res_data_pend, res_addr_pend, res_alias,
                               res_data_pend_idx, res_addr_pend_idx}), 64'h0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 first clock after release", 64'({res_valid, res_mask}), 64'h0);
    @(negedge clk);

    // R4: three overlapping older stores, youngest older wins; R3: younger store ignored
    clear_q();
    set_entry(1, 1, 1, 1, 0, 0, 8'hff, 64'h1111111111111111);
    set_entry(3, 1, 1, 1, 0, 0, 8'h0f, 64'h3333333333333333);
    set_entry(5, 1, 1, 1, 0, 0, 8'h3c, 64'h5555555555555555);
    set_entry(7, 1, 1, 1, 0, 0, 8'hff, 64'h7777777777777777);
    set_load(0, 8'hff, 8'b0111_1111);
    run("overlap");
    chk("R4 lane order explicit", res_data, 64'h1111555555553333);
    chk("R3 younger store ignored", 64'(res_data[63:56]), 64'h11);

    // R5: lanes outside every store mask stay zero
    clear_q();
    set_entry(2, 1, 1, 1, 0, 0, 8'h03, 64'habcdabcdabcdabcd);
    set_load(0, 8'h0f, 8'hff);
    run("partial");
    chk("R5 uncovered lanes zero", 64'({res_mask, res_data[31:16]}), 64'h0300_00);

    // R7: older matching store with data not ready
    clear_q();
    set_entry(0, 1, 1, 1, 1, 1, 8'hff, 64'h0102030405060708);
    set_entry(4, 1, 1, 0, 1, 1, 8'hf0, 64'h0);
    set_load(1, 8'hff, 8'h3f);
    run("data_pend");
    chk("R7 pending store index", 64'(res_data_pend_idx), 64'd4);

    // R9: alias, virtual hit but physical line different
    clear_q();
    set_entry(6, 1, 1, 1, 2, 3, 8'h0f, 64'h0);
    set_load(2, 8'hff, 8'hff);
    run("alias");
    chk("R9 alias raised", 64'(res_alias), 64'h1);

    // R8: older store with unknown address; R3: invalid entry ignored
    clear_q();
    set_entry(2, 1, 0, 1, 0, 0, 8'hff, 64'h0);
    set_entry(5, 1, 0, 1, 0, 0, 8'hff, 64'h0);
    set_entry(6, 0, 0, 0, 0, 0, 8'hff, 64'h0);
    set_load(0, 8'hff, 8'h7f);
    run("addr_pend");
    chk("R8 highest unknown index", 64'(res_addr_pend_idx), 64'd5);

    // R2/R6: no request, everything quiet
    ld_valid = 0;
    run("idle");

    for (int it = 0; it < 400; it++) begin
      for (int e = 0; e < N; e++) begin
        int vl;
        vl = $urandom % 3;
        set_entry(e, ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 4) != 0,
                  vl, (($urandom % 12) == 0) ? vl + 1 : vl, 8'($urandom),
                  {$urandom, $urandom});
      end
      set_load($urandom % 3, 8'($urandom) | 8'h01,
               (($urandom % 3) == 0) ? N'($urandom)
                                     : N'((1 << ($urandom % (N + 1))) - 1));
      if (($urandom % 10) == 0) ld_valid = 0;
      run("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule